// File: doc/BRIEF.md
# Page Map and Access Protection Checker

This block sits between a 16-bit processor and its memory. Every memory access is translated from a 16-bit logical word address to a 20-bit physical word address and checked against several protection rules. The address-state inputs choose a group of page registers. The data/instruction input chooses the data or the instruction set inside that group. The top bits of the logical address then pick one page register. That register supplies an 8-bit physical page (one of 256 pages of 4K words), a 4-bit lock, an execute-protect bit and a write-protect bit.

On top of the page registers, a bitmap marks 1K-word physical pages as write-protected. The CPU and DMA traffic each have their own bitmap, and the DMA-acknowledge input selects the DMA one. A protection violation pulls the active-low error output low. A second output works in one of two modes, set by a control bit. In strobe mode it is an active-low write strobe for legal memory writes. In flag mode it is an active-high flag that marks a write which broke a protection rule. A data-ready output goes low for one clock whenever an access lands on a different 4K page from the previous memory access, which inserts a wait state. A simple register-write port loads the page registers, both bitmaps and the mode bit.

Top module: `page_guard`

## Requirements
- R1: For a memory access (`acc_valid`=1, `is_mem`=1) sampled at a clock edge, the outputs set at that edge are as follows. `ext_addr` is the page field (bits 7:0) of the page register at index {addr_state, is_data, log_addr[15:12]}. `phys_addr` is {ext_addr, log_addr[11:0]}. Both hold their value until the next memory access.
- R2: If `acc_key` is nonzero and differs from the lock field (bits 11:8) of the selected register, `prot_err_n` is 0 for the cycle after the access.
- R3: An `acc_key` of 0 matches any lock.
- R4: An instruction access (`is_data`=0) to a register whose execute-protect bit (bit 12) is set raises `prot_err_n`=0.
- R5: A data write (`is_data`=1, `is_read`=0) to a register whose write-protect bit (bit 13) is set raises `prot_err_n`=0.
- R6: A write whose physical page index phys_addr[19:10] is marked in the CPU bitmap raises `prot_err_n`=0 when `dma_ack`=0. Reads are never blocked by the bitmap.
- R7: When `dma_ack`=1, the DMA bitmap is consulted instead of the CPU bitmap.
- R8: In strobe mode (mode bit 0, the reset default), `wp_out` is 0 for the cycle after a memory write that has no protection error. Otherwise it is 1.
- R9: In flag mode (mode bit 1), `wp_out` is 1 for the cycle after a memory write that has a protection error. Otherwise it is 0.
- R10: `data_rdy` is 0 for the cycle after a memory access whose physical page differs from that of the previous memory access, and also after the first memory access after reset. Otherwise it is 1.
- R11: An I/O access (`is_mem`=0) raises no error and no strobe, keeps `data_rdy` at 1, and leaves `ext_addr`, `phys_addr` and the current page unchanged.
- R12: After reset, `ext_addr`=0, `phys_addr`=0, `prot_err_n`=1, `wp_out`=1 and `data_rdy`=1. All page registers and bitmap bits are 0, and the mode is strobe.
- R13: When `cfg_we`=1, `cfg_target` selects what is written. 0 writes page register `cfg_addr[8:0]` with `cfg_wdata`. 1 writes CPU bitmap bit `cfg_addr[9:0]` with `cfg_wdata[0]`. 2 writes the DMA bitmap bit in the same way. 3 sets the mode from `cfg_wdata[0]`. The write affects accesses at later edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| log_addr | input | 16 | Logical word address |
| addr_state | input | 4 | Page-register group select |
| acc_key | input | 4 | Access key |
| is_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| is_data | input | 1 | 1 = data cycle, 0 = instruction cycle |
| is_read | input | 1 | 1 = read, 0 = write |
| dma_ack | input | 1 | DMA cycle, selects the DMA bitmap |
| cfg_we | input | 1 | Configuration write enable |
| cfg_target | input | 2 | Configuration target select |
| cfg_addr | input | 10 | Configuration index |
| cfg_wdata | input | 14 | Configuration data |
| ext_addr | output | 8 | Physical page (extended address) |
| phys_addr | output | 20 | Full physical word address |
| prot_err_n | output | 1 | Active-low protection error |
| wp_out | output | 1 | Write strobe or protection flag |
| data_rdy | output | 1 | Low for one wait state on a page change |

## Verification
The embedded assertions check properties on every cycle:
- a low `data_rdy` or a low `prot_err_n` is always traced back to a memory access on the previous edge;
- I/O accesses never produce an error or a wait state;
- the strobe never coincides with an error in strobe mode, and the flag never appears without an error in flag mode.

Only the bench's scenarios, checked against its behavioural model, can show the following:
- the correct translated page and physical address;
- which particular rule fired (key, master key, execute, write, CPU or DMA bitmap);
- that page misses are counted against the last memory page;
- that configuration writes land at the right index.

// File: rtl/page_guard.sv
module page_guard #(
  parameter int LA_W  = 16,
  parameter int AS_W  = 4,
  parameter int KEY_W = 4,
  parameter int EXT_W = 8,
  parameter int SEL_W = 4,
  parameter int BLK_W = 10,
  localparam int OFF_W   = LA_W - SEL_W,
  localparam int PA_W    = EXT_W + OFF_W,
  localparam int BIDX_W  = PA_W - BLK_W,
  localparam int PR_A_W  = AS_W + 1 + SEL_W,
  localparam int ENT_W   = EXT_W + KEY_W + 2,
  localparam int CFG_A_W = (PR_A_W > BIDX_W) ? PR_A_W : BIDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic [LA_W-1:0]    log_addr,
  input  logic [AS_W-1:0]    addr_state,
  input  logic [KEY_W-1:0]   acc_key,
  input  logic               is_mem,
  input  logic               is_data,
  input  logic               is_read,
  input  logic               dma_ack,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_target,
  input  logic [CFG_A_W-1:0] cfg_addr,
  input  logic [ENT_W-1:0]   cfg_wdata,
  output logic [EXT_W-1:0]   ext_addr,
  output logic [PA_W-1:0]    phys_addr,
  output logic               prot_err_n,
  output logic               wp_out,
  output logic               data_rdy
);
  localparam int NPR  = 2 ** PR_A_W;
  localparam int NBLK = 2 ** BIDX_W;
  localparam logic [1:0] T_PAGE = 2'd0;
  localparam logic [1:0] T_CPU  = 2'd1;
  localparam logic [1:0] T_DMA  = 2'd2;

  logic [ENT_W-1:0] ptab [NPR];
  logic [NBLK-1:0]  cpu_tab, dma_tab;
  logic             flag_mode, mode_q, page_vld;

  logic [PR_A_W-1:0] pr_idx;
  logic [ENT_W-1:0]  entry;
  logic [EXT_W-1:0]  page;
  logic [KEY_W-1:0]  lock;
  logic [PA_W-1:0]   phys_next;
  logic [BIDX_W-1:0] blk_idx;
  logic              is_write, key_bad, exe_bad, wrp_bad, blk_bad, any_bad, mem_acc, miss;

  assign pr_idx    = {addr_state, is_data, log_addr[LA_W-1 -: SEL_W]};
  assign entry     = ptab[pr_idx];
  assign page      = entry[EXT_W-1:0];
  assign lock      = entry[EXT_W +: KEY_W];
  assign phys_next = {page, log_addr[OFF_W-1:0]};
  assign blk_idx   = phys_next[PA_W-1 -: BIDX_W];
  assign is_write  = !is_read;
  assign key_bad   = (acc_key != '0) && (acc_key != lock);
  assign exe_bad   = !is_data && entry[EXT_W+KEY_W];
  assign wrp_bad   = is_data && is_write && entry[EXT_W+KEY_W+1];
  assign blk_bad   = is_write && (dma_ack ? dma_tab[blk_idx] : cpu_tab[blk_idx]);
  assign any_bad   = key_bad || exe_bad || wrp_bad || blk_bad;
  assign mem_acc   = acc_valid && is_mem;
  assign miss      = !page_vld || (page != ext_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPR; i++) ptab[i] <= '0;
      cpu_tab   <= '0;
      dma_tab   <= '0;
      flag_mode <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_target)
        T_PAGE:  ptab[cfg_addr[PR_A_W-1:0]] <= cfg_wdata;
        T_CPU:   cpu_tab[cfg_addr[BIDX_W-1:0]] <= cfg_wdata[0];
        T_DMA:   dma_tab[cfg_addr[BIDX_W-1:0]] <= cfg_wdata[0];
        default: flag_mode <= cfg_wdata[0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_addr   <= '0;
      phys_addr  <= '0;
      prot_err_n <= 1'b1;
      wp_out     <= 1'b1;
      data_rdy   <= 1'b1;
      page_vld   <= 1'b0;
      mode_q     <= 1'b0;
    end else begin
      mode_q <= flag_mode;
      if (mem_acc) begin
        ext_addr   <= page;
        phys_addr  <= phys_next;
        prot_err_n <= !any_bad;
        data_rdy   <= !miss;
        page_vld   <= 1'b1;
        wp_out     <= flag_mode ? (is_write && any_bad) : !(is_write && !any_bad);
      end else begin
        prot_err_n <= 1'b1;
        data_rdy   <= 1'b1;
        wp_out     <= !flag_mode;
      end
    end
  end

  // R10
  rdy_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_rdy |-> $past(acc_valid && is_mem));

  // R2
  err_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_err_n |-> $past(acc_valid && is_mem));

  // R11
  io_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !is_mem) |=> (prot_err_n && data_rdy && $stable(ext_addr)));

  // R8
  strobe_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !wp_out) |-> prot_err_n);

  // R9
  flag_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && wp_out) |-> !prot_err_n);
endmodule

// File: tb/sim_page_guard.sv
module sim_page_guard;
  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, is_mem = 0, is_data = 0, is_read = 1, dma_ack = 0, cfg_we = 0;
  logic [15:0] log_addr = 0;
  logic [3:0]  addr_state = 0, acc_key = 0;
  logic [1:0]  cfg_target = 0;
  logic [9:0]  cfg_addr = 0;
  logic [13:0] cfg_wdata = 0;
  logic [7:0]  ext_addr;
  logic [19:0] phys_addr;
  logic        prot_err_n, wp_out, data_rdy;

  int checks = 0, failures = 0;

  page_guard u0 (.*);

  always #10 clk = ~clk;

  // reference model state
  int pr [512];
  bit ctab [1024];
  bit dtab [1024];
  bit flag = 0;
  int last_page = -1;
  int e_ext = 0, e_phys = 0;
  bit e_err = 1, e_wp = 1, e_rdy = 1;
  string t_err = "R1", t_wp = "R8", t_addr = "R1";
  bit model_on = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (pr[i]) pr[i] = 0;
      foreach (ctab[i]) begin ctab[i] = 0; dtab[i] = 0; end
      flag = 0; last_page = -1;
      e_ext = 0; e_phys = 0; e_err = 1; e_wp = 1; e_rdy = 1;
    end else begin
      if (acc_valid && is_mem) begin
        int idx, e, pg, lk, bi;
        bit kb, k0, xb, wb, bb, wr, bad;
        idx = int'(addr_state) * 32 + int'(is_data) * 16 + int'(log_addr[15:12]);
        e = pr[idx]; pg = e % 256; lk = (e / 256) % 16;
        wr = !is_read;
        kb = (acc_key != 0) && (int'(acc_key) != lk);
        k0 = (acc_key == 0) && (lk != 0);
        xb = !is_data && (((e / 4096) % 2) == 1);
        wb = is_data && wr && (((e / 8192) % 2) == 1);
        e_phys = pg * 4096 + int'(log_addr[11:0]);
        bi = e_phys / 1024;
        bb = wr && (dma_ack ? dtab[bi] : ctab[bi]);
        bad = kb || xb || wb || bb;
        e_ext = pg; e_err = !bad;
        e_wp = flag ? (wr && bad) : !(wr && !bad);
        e_rdy = (pg == last_page);
        last_page = pg;
        t_addr = "R1";
        if (kb) t_err = "R2"; else if (k0) t_err = "R3"; else if (xb) t_err = "R4";
        else if (wb) t_err = "R5"; else if (bb && dma_ack) t_err = "R7";
        else if (bb) t_err = "R6"; else t_err = dma_ack ? "R7" : "R1";
        t_wp = flag ? "R9" : "R8";
      end else begin
        e_err = 1; e_rdy = 1; e_wp = !flag;
        t_err = acc_valid ? "R11" : "R1"; t_addr = acc_valid ? "R11" : "R1";
        t_wp = flag ? "R9" : "R8";
      end
      if (cfg_we) begin
        case (cfg_target)
          2'd0: pr[int'(cfg_addr) % 512] = int'(cfg_wdata);
          2'd1: ctab[int'(cfg_addr)] = cfg_wdata[0];
          2'd2: dtab[int'(cfg_addr)] = cfg_wdata[0];
          default: flag = cfg_wdata[0];
        endcase
      end
    end
  end

  task automatic chk(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && model_on) begin
      chk(t_addr, int'(ext_addr), e_ext, "ext_addr");
      chk(t_addr, int'(phys_addr), e_phys, "phys_addr");
      chk(t_err, int'(prot_err_n), int'(e_err), "prot_err_n");
      chk(t_wp, int'(wp_out), int'(e_wp), "wp_out");
      chk(acc_valid ? "R11" : "R10", int'(data_rdy), int'(e_rdy), "data_rdy");
    end
  end

  task automatic idle();
    acc_valid = 0; cfg_we = 0;
    @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] tgt, input int addr, input int data);
    acc_valid = 0; cfg_we = 1; cfg_target = tgt;
    cfg_addr = 10'(addr); cfg_wdata = 14'(data);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic acc(input int as_, input int la, input int key, input bit mem,
                     input bit dat, input bit rd, input bit dma);
    cfg_we = 0; acc_valid = 1; addr_state = 4'(as_); log_addr = 16'(la);
    acc_key = 4'(key); is_mem = mem; is_data = dat; is_read = rd; dma_ack = dma;
    @(negedge clk);
    acc_valid = 0;
  endtask

  function automatic int ent(int pg, int lk, bit xp, bit wp);
    return pg + lk * 256 + int'(xp) * 4096 + int'(wp) * 8192;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12", int'(ext_addr), 0, "ext_addr reset");
    chk("R12", int'(phys_addr), 0, "phys_addr reset");
    chk("R12", int'(prot_err_n), 1, "prot_err_n reset");
    chk("R12", int'(wp_out), 1, "wp_out reset");
    chk("R12", int'(data_rdy), 1, "data_rdy reset");
    rst_n = 1; model_on = 1;
    idle();

    // R13 page registers: index = as*32 + data*16 + entry
    cfg(0, 3*32 + 16 + 5, ent(8'h42, 6, 0, 0));
    cfg(0, 3*32 + 0 + 5,  ent(8'h17, 6, 1, 0));
    cfg(0, 3*32 + 16 + 6, ent(8'h55, 0, 0, 1));
    cfg(0, 1*32 + 16 + 0, ent(8'h42, 2, 0, 0));

    acc(3, 16'h5123, 6, 1, 1, 1, 0);
    chk("R1", int'(ext_addr), 8'h42, "translated page");
    chk("R1", int'(phys_addr), 20'h42123, "phys");
    chk("R10", int'(data_rdy), 0, "first access miss");
    chk("R2", int'(prot_err_n), 1, "matching key");
    acc(3, 16'h5777, 6, 1, 1, 1, 0);
    chk("R10", int'(data_rdy), 1, "same page hit");
    acc(3, 16'h5000, 9, 1, 1, 1, 0);
    chk("R2", int'(prot_err_n), 0, "key mismatch");
    acc(3, 16'h5000, 0, 1, 1, 1, 0);
    chk("R3", int'(prot_err_n), 1, "master key");
    acc(3, 16'h5000, 6, 1, 0, 1, 0);
    chk("R4", int'(prot_err_n), 0, "execute protect");
    chk("R10", int'(data_rdy), 0, "page change");
    acc(3, 16'h6000, 0, 1, 1, 0, 0);
    chk("R5", int'(prot_err_n), 0, "write protect");
    chk("R8", int'(wp_out), 1, "no strobe on bad write");
    acc(3, 16'h6000, 0, 1, 1, 1, 0);
    chk("R5", int'(prot_err_n), 1, "read of write-protected page");

    // R6/R7 bitmap: phys 0x42400 -> index 0x42*4+1
    cfg(1, 8'h42 * 4 + 1, 1);
    acc(3, 16'h5400, 6, 1, 1, 0, 0);
    chk("R6", int'(prot_err_n), 0, "cpu bitmap write");
    acc(3, 16'h5400, 6, 1, 1, 1, 0);
    chk("R6", int'(prot_err_n), 1, "cpu bitmap read ok");
    acc(3, 16'h5000, 6, 1, 1, 0, 0);
    chk("R8", int'(wp_out), 0, "strobe on legal write");
    acc(3, 16'h5400, 6, 1, 1, 0, 1);
    chk("R7", int'(prot_err_n), 1, "dma table clear");
    cfg(2, 8'h42 * 4 + 2, 1);
    acc(3, 16'h5800, 6, 1, 1, 0, 1);
    chk("R7", int'(prot_err_n), 0, "dma table set");
    acc(3, 16'h5800, 6, 1, 1, 0, 0);
    chk("R7", int'(prot_err_n), 1, "cpu ignores dma table");

    // R11 I/O bypass
    acc(0, 16'hF00F, 9, 0, 1, 0, 0);
    chk("R11", int'(ext_addr), 8'h42, "io keeps page");
    chk("R11", int'(prot_err_n), 1, "io no error");
    chk("R11", int'(wp_out), 1, "io no strobe");
    acc(1, 16'h0042, 2, 1, 1, 1, 0);
    chk("R10", int'(data_rdy), 1, "same physical page, other group");

    // R9 flag mode
    cfg(3, 0, 1);
    idle();
    chk("R9", int'(wp_out), 0, "flag idle low");
    acc(3, 16'h5400, 6, 1, 1, 0, 0);
    chk("R9", int'(wp_out), 1, "flag on bad write");
    acc(3, 16'h5000, 6, 1, 1, 0, 0);
    chk("R9", int'(wp_out), 0, "no flag on good write");
    cfg(3, 0, 0);
    idle();

    // random stream against the model
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 8 == 0) begin
        int t = $urandom % 4;
        int d = int'($urandom % 16384) & ~(12 * 256);
        cfg(2'(t), int'($urandom % 1024), d);
      end else if ($urandom % 6 == 0) begin
        idle();
      end else begin
        acc(int'($urandom % 4), int'($urandom % 65536), int'($urandom % 4),
            ($urandom % 8) != 0, $urandom % 2, $urandom % 2, ($urandom % 4) == 0);
      end
    end
    idle(); idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule